// File: doc/BRIEF.md
# Two-Level Nested Interrupt Acceptance Gate

This block decides, at each processor acceptance point, whether one of several pending interrupt requests may be taken. It keeps a two-bit nesting level: level 0 while the normal program runs, level 1 while any interrupt is being serviced, and level 2 while the designated high-order source is being serviced on top of another. A select input names the one source that counts as high-order. Level 0 admits any source. Level 1 admits only the high-order source. Level 2 admits nothing.

When a request is accepted, the block pulses a grant for one cycle and reports the winning source number. On the same edge it pushes the current level onto a small save stack and raises the level by one. A return strobe pops the saved level back. If a return and an accept strobe coincide, the block handles the return first and judges acceptance against the restored level. A return with nothing saved forces level 0 and pulses an underflow flag.

Top module: `nest_irq_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `level` is 0 and `grant` and `underflow` are 0.
- R2: At level 0, a cycle with `accept_stb` and `int_en` high and at least one request pending grants a source. The source is `hi_src` if its request is pending; otherwise it is the lowest-numbered pending source.
- R3: At level 1, only the source numbered `hi_src` can be granted. Requests from any other source produce no grant and leave the level unchanged.
- R4: At level 2, no request is granted, whatever is pending.
- R5: `level` is only ever 0, 1 or 2. The encoding 3 is never produced, and no grant is made while the level would be 3.
- R6: With `int_en` low, or with `accept_stb` low, no grant occurs and `level` is unchanged.
- R7: A grant is a one-cycle pulse on `grant`. On the same edge `grant_id` takes the winning source number and `level` rises by exactly one.
- R8: A `return_stb` with a level saved restores the most recently saved level on the next edge.
- R9: A `return_stb` with nothing saved sets `level` to 0 and pulses `underflow` for one cycle.
- R10: When `return_stb` and `accept_stb` are high in the same cycle, the pop is applied first, and the acceptance rule of R2 to R4 uses the restored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Pending request per source |
| hi_src | input | log2(NSRC) | Number of the high-order source |
| int_en | input | 1 | Master interrupt enable |
| accept_stb | input | 1 | Acceptance point: grant now if allowed |
| return_stb | input | 1 | Return from interrupt: restore saved level |
| grant | output | 1 | One-cycle grant pulse |
| grant_id | output | log2(NSRC) | Granted source number, valid with `grant` |
| level | output | 2 | Current nesting level (0, 1, 2) |
| underflow | output | 1 | One-cycle pulse on return with empty save stack |

## Verification
A corrupted level shows at the ports on the very next acceptance point. Sources are then admitted or refused against the wrong rule, or `level` itself reads the wrong value one edge after the grant or return that disturbed it. A save stack that has lost or duplicated an entry stays hidden until the matching return, when `level` comes back wrong or `underflow` pulses at the wrong time. The bench therefore sweeps every request pattern and every high-order select at each level, and climbs and unwinds the stack between cases.

// File: rtl/nest_irq_gate.sv
module nest_irq_gate #(
  parameter int NSRC  = 8,
  parameter int DEPTH = 2,
  localparam int IW = $clog2(NSRC),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [IW-1:0]   hi_src,
  input  logic            int_en,
  input  logic            accept_stb,
  input  logic            return_stb,
  output logic            grant,
  output logic [IW-1:0]   grant_id,
  output logic [1:0]      level,
  output logic            underflow
);

  logic [1:0]    stk [DEPTH];
  logic [CW-1:0] cnt;
  logic [1:0]    lvl_r;
  logic [IW-1:0] low_idx;
  logic          empty, pop, hi_ok, eligible, acc;
  logic [IW-1:0] win;

  assign empty = (cnt == '0);
  assign pop   = return_stb && !empty;
  assign lvl_r = return_stb ? (empty ? 2'd0 : stk[0]) : level;
  assign hi_ok = irq_req[hi_src];

  always_comb begin
    low_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (irq_req[i]) low_idx = IW'(i);
  end

  always_comb begin
    case (lvl_r)
      2'd0:    eligible = |irq_req;
      2'd1:    eligible = hi_ok;
      default: eligible = 1'b0;
    endcase
  end

  assign win = (lvl_r == 2'd0 && !hi_ok) ? low_idx : hi_src;
  assign acc = accept_stb && int_en && eligible;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= 1'b0;
      grant_id  <= '0;
      level     <= 2'd0;
      underflow <= 1'b0;
    end else begin
      grant     <= acc;
      underflow <= return_stb && empty;
      level     <= acc ? lvl_r + 2'd1 : lvl_r;
      if (acc) grant_id <= win;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= 2'd0;
    end else if (acc && !pop) begin
      stk[0] <= lvl_r;
      for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
      cnt <= cnt + CW'(1);
    end else if (pop && !acc) begin
      for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
      stk[DEPTH-1] <= 2'd0;
      cnt <= cnt - CW'(1);
    end else if (acc && pop) begin
      stk[0] <= lvl_r;
    end
  end

  p_level_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'd3);

  p_grant_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(int_en && accept_stb));

  p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !$past(return_stb)) |-> level == $past(level) + 2'd1);

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level) == 2'd2 && !$past(return_stb)) |-> !grant);

  p_hi_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && $past(lvl_r) == 2'd1) |-> grant_id == $past(hi_src));

  p_underflow_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (level == 2'd0 || (grant && level == 2'd1)));

endmodule

// File: tb/nest_irq_gate_bench.sv
`timescale 1ns/1ps
module nest_irq_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic [2:0] hi_src = '0;
  logic       int_en = 1'b0, accept_stb = 1'b0, return_stb = 1'b0;
  logic       grant, underflow;
  logic [2:0] grant_id;
  logic [1:0] level;

  int checks = 0, errors = 0;
  int m_lvl = 0, m_cnt = 0;
  int m_stk [2];
  bit seen3 = 0;

  always #4 clk = ~clk;

  nest_irq_gate #(.NSRC(8), .DEPTH(2)) u_nest_irq_gate (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .hi_src(hi_src),
    .int_en(int_en), .accept_stb(accept_stb), .return_stb(return_stb),
    .grant(grant), .grant_id(grant_id), .level(level), .underflow(underflow));

  task automatic step(input bit tk, input bit rt, input bit en,
                      input logic [7:0] rq, input logic [2:0] hs, input string tag);
    int rest, idx;
    bit elig, acc, eerr, okv;
    eerr = rt && (m_cnt == 0);
    rest = rt ? ((m_cnt == 0) ? 0 : m_stk[0]) : m_lvl;
    if (rt && m_cnt > 0) begin
      m_stk[0] = m_stk[1]; m_stk[1] = 0; m_cnt--;
    end
    elig = (rest == 0) ? (rq != 0) : (rest == 1) ? rq[hs] : 1'b0;
    acc = tk && en && elig;
    idx = hs;
    if (rest == 0 && !rq[hs])
      for (int i = 7; i >= 0; i--) if (rq[i]) idx = i;
    if (acc) begin
      m_stk[1] = m_stk[0]; m_stk[0] = rest; m_cnt++;
    end
    m_lvl = acc ? rest + 1 : rest;
    irq_req = rq; hi_src = hs; int_en = en; accept_stb = tk; return_stb = rt;
    @(posedge clk);
    @(negedge clk);
    accept_stb = 1'b0; return_stb = 1'b0;
    if (level == 2'd3) seen3 = 1;
    okv = (grant == acc) && (int'(level) == m_lvl) && (underflow == eerr) &&
          (!acc || int'(grant_id) == idx);
    checks++;
    if (!okv) begin
      errors++;
      $display("FAIL %s: grant=%0b id=%0d level=%0d uf=%0b expected grant=%0b id=%0d level=%0d uf=%0b",
               tag, grant, grant_id, level, underflow, acc, idx, m_lvl, eerr);
    end
  endtask

  task automatic go_level(input int tgt, input logic [2:0] hs);
    while (m_lvl > tgt) step(1'b0, 1'b1, 1'b1, 8'h00, hs, "R8");
    while (m_lvl < tgt) step(1'b1, 1'b0, 1'b1, 8'(1 << hs), hs, "R7");
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (level !== 2'd0 || grant !== 1'b0 || underflow !== 1'b0) begin
      errors++;
      $display("FAIL R1: level=%0d grant=%0b uf=%0b expected 0 0 0", level, grant, underflow);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (level !== 2'd0 || grant !== 1'b0 || underflow !== 1'b0) begin
      errors++;
      $display("FAIL R1: after release level=%0d grant=%0b uf=%0b expected 0 0 0", level, grant, underflow);
    end

    for (int lv = 0; lv < 3; lv++)
      for (int hs = 0; hs < 8; hs++)
        for (int p = 0; p < 256; p++) begin
          go_level(lv, 3'(hs));
          step(1'b1, 1'b0, 1'b1, 8'(p), 3'(hs),
               lv == 0 ? "R2 R7" : lv == 1 ? "R3 R7" : "R4");
        end

    go_level(0, 3'd0);
    for (int p = 1; p < 256; p++) begin
      step(1'b1, 1'b0, 1'b0, 8'(p), 3'(p % 8), "R6");
      step(1'b0, 1'b0, 1'b1, 8'(p), 3'(p % 8), "R6");
    end

    go_level(0, 3'd0);
    step(1'b0, 1'b1, 1'b1, 8'h00, 3'd0, "R9");
    step(1'b0, 1'b1, 1'b1, 8'hFF, 3'd2, "R9");
    step(1'b1, 1'b1, 1'b1, 8'h30, 3'd1, "R9 R10");
    step(1'b0, 1'b0, 1'b1, 8'h00, 3'd1, "R7");

    for (int hs = 0; hs < 8; hs++) begin
      go_level(2, 3'(hs));
      step(1'b1, 1'b1, 1'b1, 8'(1 << hs), 3'(hs), "R10");
      step(1'b1, 1'b1, 1'b1, 8'(~(1 << hs)), 3'(hs), "R10");
      go_level(1, 3'(hs));
      step(1'b1, 1'b1, 1'b1, 8'(~(1 << hs)), 3'(hs), "R10");
      go_level(0, 3'(hs));
      step(1'b0, 1'b0, 1'b1, 8'h00, 3'(hs), "R8");
    end

    checks++;
    if (seen3) begin
      errors++;
      $display("FAIL R5: level reached 3, expected never");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule